// File: doc/BRIEF.md
# UART Loopback and Modem Status Router

This block sits between a serial core (UART plus infrared transmitter) and the chip pins. In normal operation it passes the core's transmit lines out to the pins, hands the received serial lines to the core, and gives the core the external modem status lines. Before those status lines are used, they pass through a two-stage synchronizer.

When self-test loopback is on, the block ties each core transmit line back to the matching core receive input and ignores the receive pins. It holds the UART transmit pin at its idle high level. It holds the IR transmit pin low, unless an IR override bit lets that pin follow the core. The external modem status lines are disconnected, and the core's status is built from the modem control bits instead. The mapping depends on the mode:

- Standard mode: each control bit drives one status line.
- Extended mode: each of two control bits drives a pair of status lines.

The loopback enable is one storage bit with two write aliases, a standard-mode alias and an extended-mode alias. Software can use either. The current value of the bit is visible on `lb_active`.

Top module: `uart_lb_router`

## Requirements
- R1: After reset, `lb_active` is 0, `pin_tx_uart` is 1, `pin_tx_ir` is 0 and `core_msr` is 4'b0000.
- R2: With loopback off, `pin_tx_uart` and `pin_tx_ir` show the values `core_tx_uart` and `core_tx_ir` had one clock earlier.
- R3: With loopback off, `core_rx_uart` equals `pin_rx_uart` and `core_rx_ir` equals `pin_rx_ir` in the same cycle.
- R4: With loopback off, `core_msr` equals `pin_msr` as it was two clock edges earlier.
- R5: With loopback on, `core_rx_uart` equals `core_tx_uart` and `core_rx_ir` equals `core_tx_ir`, whatever the receive pins carry.
- R6: With loopback on, `pin_tx_uart` is 1 from the following clock edge on.
- R7: With loopback on, `pin_tx_ir` is 0 one edge later when `ir_lb_ovr` is 0. When `ir_lb_ovr` is 1, it shows the previous cycle's `core_tx_ir`.
- R8: Status bits are [0]=CTS, [1]=DSR, [2]=RI and [3]=DCD. Control bits are [0]=DTR, [1]=RTS, [2]=OUT1 and [3]=OUT2. With loopback on and `ext_mode` at 0, the routing is DSR=DTR, CTS=RTS, RI=OUT1 and DCD=OUT2, and `pin_msr` is ignored.
- R9: With loopback on and `ext_mode` at 1, DSR and RI both equal DTR, and CTS and DCD both equal RTS.
- R10: Either alias (`lb_wr_std`/`lb_wd_std` or `lb_wr_ext`/`lb_wd_ext`) writes the same loopback bit, which appears on `lb_active` after the edge. If both aliases write in the same cycle, the extended alias wins.
- R11: A change of the loopback bit switches `core_rx_*` and `core_msr` in the same cycle as `lb_active`. It switches the transmit pins one edge later, and only through registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lb_wr_std | input | 1 | Write strobe, standard-mode alias of the loopback bit |
| lb_wd_std | input | 1 | Write data, standard-mode alias |
| lb_wr_ext | input | 1 | Write strobe, extended-mode alias |
| lb_wd_ext | input | 1 | Write data, extended-mode alias |
| ext_mode | input | 1 | Extended mode select |
| ir_lb_ovr | input | 1 | Lets the IR transmit pin run during loopback |
| mcr_ctl | input | 4 | Modem control bits {OUT2,OUT1,RTS,DTR} |
| core_tx_uart | input | 1 | Core UART serial output |
| core_tx_ir | input | 1 | Core IR serial output |
| pin_rx_uart | input | 1 | UART receive pin |
| pin_rx_ir | input | 1 | IR receive pin |
| pin_msr | input | 4 | External modem status {DCD,RI,DSR,CTS}, asynchronous |
| pin_tx_uart | output | 1 | UART transmit pin, registered |
| pin_tx_ir | output | 1 | IR transmit pin, registered |
| core_rx_uart | output | 1 | UART receive input to the core |
| core_rx_ir | output | 1 | IR receive input to the core |
| core_msr | output | 4 | Modem status to the core |
| lb_active | output | 1 | Current loopback bit |

## Verification
The bench keeps a cycle-level model and drives random transmit, receive, status and control values. The loopback bit is rewritten through random aliases at random times, so that each check catches the edge where the routing flips.

Random `ext_mode` and `ir_lb_ovr` values under loopback separate the one-to-one status mapping from the paired mapping, and the forced-low IR pin from the followed one. Receive-pin toggling during loopback shows whether the pins leak into the core. A directed cycle in which both aliases write opposite values tells the alias priority apart from a simple OR of the strobes.

// File: rtl/uart_lb_pkg.sv
// Shared bit positions for the modem control and status vectors.
// Assumes the conventional 4-bit layouts stated in the brief.
package uart_lb_pkg;
    localparam int MODEM_W = 4;
    // Status vector positions
    localparam int S_CTS = 0;
    localparam int S_DSR = 1;
    localparam int S_RI  = 2;
    localparam int S_DCD = 3;
    // Control vector positions
    localparam int C_DTR  = 0;
    localparam int C_RTS  = 1;
    localparam int C_OUT1 = 2;
    localparam int C_OUT2 = 3;
    typedef logic [MODEM_W-1:0] modem_t;
endpackage

// File: rtl/uart_lb_ctl.sv
// Loopback enable storage: one bit reachable through two write aliases.
// Assumes both aliases may strobe in the same cycle; the extended alias wins.
module uart_lb_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_std,
    input  logic wd_std,
    input  logic wr_ext,
    input  logic wd_ext,
    output logic lb_q
);
    // Update the shared bit from whichever alias writes, extended first.
    always_ff @(posedge clk) begin
        if (!rst_n)      lb_q <= 1'b0;
        else if (wr_ext) lb_q <= wd_ext;
        else if (wr_std) lb_q <= wd_std;
    end
endmodule

// File: rtl/uart_lb_sync.sv
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent (no multi-bit coherency required).
module uart_lb_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // Shift the vector one stage along the chain.
        always_ff @(posedge clk) begin
            if (!rst_n)      chain[s] <= '0;
            else if (s == 0) chain[s] <= d;
            else             chain[s] <= chain[(s == 0) ? 0 : s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/uart_lb_msr_map.sv
// Selects the modem status seen by the core: synchronized pins, or the
// control bits folded back in standard or extended loopback style.
module uart_lb_msr_map
    import uart_lb_pkg::*;
(
    input  logic   lb_on,
    input  logic   ext_mode,
    input  modem_t mcr_ctl,
    input  modem_t pin_sync,
    output modem_t msr_out
);
    modem_t folded;

    // Build the looped-back status vector for the current mode.
    always_comb begin
        folded        = '0;
        folded[S_DSR] = mcr_ctl[C_DTR];
        folded[S_CTS] = mcr_ctl[C_RTS];
        if (ext_mode) begin
            folded[S_RI]  = mcr_ctl[C_DTR];
            folded[S_DCD] = mcr_ctl[C_RTS];
        end else begin
            folded[S_RI]  = mcr_ctl[C_OUT1];
            folded[S_DCD] = mcr_ctl[C_OUT2];
        end
    end

    assign msr_out = lb_on ? folded : pin_sync;
endmodule

// File: rtl/uart_lb_pin_drv.sv
// Registered transmit pin drivers with loopback forcing levels.
// Assumes UART idle is high and IR idle is low.
module uart_lb_pin_drv #(
    parameter logic UART_IDLE = 1'b1,
    parameter logic IR_IDLE   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lb_on,
    input  logic ir_ovr,
    input  logic tx_uart,
    input  logic tx_ir,
    output logic pin_uart,
    output logic pin_ir
);
    // Register the pins so mode changes cannot glitch them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_uart <= UART_IDLE;
            pin_ir   <= IR_IDLE;
        end else if (lb_on) begin
            pin_uart <= UART_IDLE;
            pin_ir   <= ir_ovr ? tx_ir : IR_IDLE;
        end else begin
            pin_uart <= tx_uart;
            pin_ir   <= tx_ir;
        end
    end
endmodule

// File: rtl/uart_lb_router.sv
// Top: routing layer between the serial core and its pins, with a
// self-test loopback mode. Assumes receive pins are synchronized inside
// the core; the modem status pins are synchronized here.
module uart_lb_router
    import uart_lb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lb_wr_std,
    input  logic               lb_wd_std,
    input  logic               lb_wr_ext,
    input  logic               lb_wd_ext,
    input  logic               ext_mode,
    input  logic               ir_lb_ovr,
    input  logic [MODEM_W-1:0] mcr_ctl,
    input  logic               core_tx_uart,
    input  logic               core_tx_ir,
    input  logic               pin_rx_uart,
    input  logic               pin_rx_ir,
    input  logic [MODEM_W-1:0] pin_msr,
    output logic               pin_tx_uart,
    output logic               pin_tx_ir,
    output logic               core_rx_uart,
    output logic               core_rx_ir,
    output logic [MODEM_W-1:0] core_msr,
    output logic               lb_active
);
    logic   lb_q;
    modem_t msr_sync;

    uart_lb_ctl u_ctl (
        .clk(clk), .rst_n(rst_n),
        .wr_std(lb_wr_std), .wd_std(lb_wd_std),
        .wr_ext(lb_wr_ext), .wd_ext(lb_wd_ext),
        .lb_q(lb_q)
    );

    uart_lb_sync #(.W(MODEM_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_msr), .q(msr_sync)
    );

    uart_lb_msr_map u_map (
        .lb_on(lb_q), .ext_mode(ext_mode), .mcr_ctl(mcr_ctl),
        .pin_sync(msr_sync), .msr_out(core_msr)
    );

    uart_lb_pin_drv u_drv (
        .clk(clk), .rst_n(rst_n), .lb_on(lb_q), .ir_ovr(ir_lb_ovr),
        .tx_uart(core_tx_uart), .tx_ir(core_tx_ir),
        .pin_uart(pin_tx_uart), .pin_ir(pin_tx_ir)
    );

    // Receive path: loop the core's own transmit back, or take the pins.
    assign core_rx_uart = lb_q ? core_tx_uart : pin_rx_uart;
    assign core_rx_ir   = lb_q ? core_tx_ir   : pin_rx_ir;
    assign lb_active    = lb_q;
endmodule

// File: rtl/uart_lb_router_chk.sv
// Checker for uart_lb_router, attached with bind.
module uart_lb_router_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       lb_wr_std,
    input logic       lb_wd_std,
    input logic       lb_wr_ext,
    input logic       lb_wd_ext,
    input logic       ext_mode,
    input logic       ir_lb_ovr,
    input logic       core_tx_uart,
    input logic       core_tx_ir,
    input logic       pin_tx_uart,
    input logic       pin_tx_ir,
    input logic       core_rx_uart,
    input logic       core_rx_ir,
    input logic [3:0] core_msr,
    input logic       lb_active
);
    assert_pass_tx_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lb_active |=> pin_tx_uart == $past(core_tx_uart) && pin_tx_ir == $past(core_tx_ir));

    assert_rx_loop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lb_active |-> core_rx_uart == core_tx_uart && core_rx_ir == core_tx_ir);

    assert_uart_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lb_active |=> pin_tx_uart);

    assert_ir_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lb_active && !ir_lb_ovr |=> !pin_tx_ir);

    assert_ext_pairs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lb_active && ext_mode |-> core_msr[1] == core_msr[2] && core_msr[0] == core_msr[3]);

    assert_ext_alias_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lb_wr_ext |=> lb_active == $past(lb_wd_ext));

    assert_std_alias_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lb_wr_std && !lb_wr_ext |=> lb_active == $past(lb_wd_std));
endmodule

bind uart_lb_router uart_lb_router_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .lb_wr_std(lb_wr_std), .lb_wd_std(lb_wd_std),
    .lb_wr_ext(lb_wr_ext), .lb_wd_ext(lb_wd_ext),
    .ext_mode(ext_mode), .ir_lb_ovr(ir_lb_ovr),
    .core_tx_uart(core_tx_uart), .core_tx_ir(core_tx_ir),
    .pin_tx_uart(pin_tx_uart), .pin_tx_ir(pin_tx_ir),
    .core_rx_uart(core_rx_uart), .core_rx_ir(core_rx_ir),
    .core_msr(core_msr), .lb_active(lb_active)
);

// File: tb/uart_lb_router_tb_top.sv
module uart_lb_router_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_CYCLES   = 3000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lb_wr_std = 0, lb_wd_std = 0, lb_wr_ext = 0, lb_wd_ext = 0;
    logic       ext_mode = 0, ir_lb_ovr = 0;
    logic [3:0] mcr_ctl = '0, pin_msr = '0;
    logic       core_tx_uart = 1, core_tx_ir = 0, pin_rx_uart = 1, pin_rx_ir = 0;
    logic       pin_tx_uart, pin_tx_ir, core_rx_uart, core_rx_ir, lb_active;
    logic [3:0] core_msr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // Model state
    logic       m_lb = 0, m_uart = 1, m_ir = 0;
    logic [3:0] m_s1 = '0, m_s2 = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_lb_router dut_i (
        .clk(clk), .rst_n(rst_n),
        .lb_wr_std(lb_wr_std), .lb_wd_std(lb_wd_std),
        .lb_wr_ext(lb_wr_ext), .lb_wd_ext(lb_wd_ext),
        .ext_mode(ext_mode), .ir_lb_ovr(ir_lb_ovr), .mcr_ctl(mcr_ctl),
        .core_tx_uart(core_tx_uart), .core_tx_ir(core_tx_ir),
        .pin_rx_uart(pin_rx_uart), .pin_rx_ir(pin_rx_ir), .pin_msr(pin_msr),
        .pin_tx_uart(pin_tx_uart), .pin_tx_ir(pin_tx_ir),
        .core_rx_uart(core_rx_uart), .core_rx_ir(core_rx_ir),
        .core_msr(core_msr), .lb_active(lb_active)
    );

    // Expected status under loopback (R8 standard, R9 extended).
    function automatic logic [3:0] fold_msr(input logic [3:0] c, input logic ext);
        logic [3:0] r;
        r[1] = c[0];
        r[0] = c[1];
        r[2] = ext ? c[0] : c[2];
        r[3] = ext ? c[1] : c[3];
        return r;
    endfunction

    task automatic check(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every output with the model for the current inputs.
    task automatic check_all(input bit first);
        string rq_tx, rq_rx, rq_ms;
        rq_tx = first ? "R1" : (m_lb ? "R6/R7/R11" : "R2/R11");
        rq_rx = m_lb ? "R5" : "R3";
        rq_ms = first ? "R1" : (m_lb ? (ext_mode ? "R9" : "R8") : "R4");
        check(first ? "R1" : "R10", "lb_active", {3'b0, lb_active}, {3'b0, m_lb});
        check(rq_tx, "pin_tx_uart", {3'b0, pin_tx_uart}, {3'b0, m_uart});
        check(rq_tx, "pin_tx_ir", {3'b0, pin_tx_ir}, {3'b0, m_ir});
        check(rq_rx, "core_rx_uart", {3'b0, core_rx_uart}, {3'b0, m_lb ? core_tx_uart : pin_rx_uart});
        check(rq_rx, "core_rx_ir", {3'b0, core_rx_ir}, {3'b0, m_lb ? core_tx_ir : pin_rx_ir});
        check(rq_ms, "core_msr", core_msr, m_lb ? fold_msr(mcr_ctl, ext_mode) : m_s2);
    endtask

    // Advance the model over the coming clock edge using the new inputs.
    task automatic model_step();
        logic nlb;
        nlb = m_lb;
        if (lb_wr_ext)      nlb = lb_wd_ext;
        else if (lb_wr_std) nlb = lb_wd_std;
        if (m_lb) begin
            m_uart = 1'b1;
            m_ir   = ir_lb_ovr ? core_tx_ir : 1'b0;
        end else begin
            m_uart = core_tx_uart;
            m_ir   = core_tx_ir;
        end
        m_s2 = m_s1;
        m_s1 = pin_msr;
        m_lb = nlb;
    endtask

    task automatic randomize_inputs();
        lb_wr_std    = ($urandom % 10) == 0;
        lb_wd_std    = $urandom;
        lb_wr_ext    = ($urandom % 12) == 0;
        lb_wd_ext    = $urandom;
        ext_mode     = $urandom;
        ir_lb_ovr    = $urandom;
        mcr_ctl      = $urandom;
        pin_msr      = $urandom;
        core_tx_uart = $urandom;
        core_tx_ir   = $urandom;
        pin_rx_uart  = $urandom;
        pin_rx_ir    = $urandom;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all(1);  // R1 reset state
        for (int i = 0; i < N_CYCLES; i++) begin
            randomize_inputs();
            // Directed: both aliases write opposite values; extended wins (R10).
            if (i == 5)  begin lb_wr_std = 1; lb_wd_std = 0; lb_wr_ext = 1; lb_wd_ext = 1; end
            if (i == 20) begin lb_wr_std = 1; lb_wd_std = 1; lb_wr_ext = 1; lb_wd_ext = 0; end
            // Directed: std alias alone turns loopback on (R10).
            if (i == 40) begin lb_wr_std = 1; lb_wd_std = 1; lb_wr_ext = 0; end
            model_step();
            @(negedge clk);
            check_all(0);
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule